// File: doc/BRIEF.md
# Nibble-to-Symbol Gearbox (4 in, 10 out)

This block sits after a quarter-rate clock and data recovery path. On every clock edge it takes a 4-bit slice of the recovered serial stream and turns the stream into 10-bit symbols for the link layer. The ratio is not an integer, so five input slices (20 bits) become exactly two output symbols. No bit is dropped and no bit is repeated.

Each slice is shifted into a 12-bit staging register. A small controller tracks how many staged bits are still waiting. When at least ten are present, it tells the output multiplexer which ten bits to take. The two possible picks are an alignment at offset 0 and one at offset 2. The chosen bits are registered in an output flop bank, and a one-cycle valid strobe marks each finished symbol. Word alignment to symbol boundaries and line decoding belong to later stages.

All logic runs on one clock. The block accepts one slice on every edge where reset is released. A synchronous reset throws away any partly collected bits and starts the 5-slice cycle again.

Top module: `nib2sym_gearbox`

## Requirements
- R1: While `rstN` is low at a clock edge, the edge leaves `outValid` at 0 and `outWord` at 0, whatever value `inNib` has.
- R2: Number the edges after reset release 0, 1, 2, and so on. Edge e samples slice e. `outValid` is high after edge e exactly when e mod 5 is 3, or when e mod 5 is 0 and e > 0. Consecutive strobes are therefore 2 or 3 cycles apart and never adjacent.
- R3: Serial bit s is bit s mod 4 of slice s/4, so bit 0 of a slice is its earliest bit. Symbol k holds serial bits 10k to 10k+9, with bit j of `outWord` carrying serial bit 10k+j. This holds for every even k.
- R4: Odd symbols come from the shifted alignment. Symbol 2g+1 holds bits 3:2 of slice 5g+2, then all of slice 5g+3, then all of slice 5g+4, in that order from `outWord` bit 0 upward.
- R5: `outWord` keeps its value in every cycle where `outValid` is low.
- R6: A reset asserted mid-stream throws away all bits not yet emitted. After release, the first symbol is built only from slices 0 to 2 of the new stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered clock; one slice is sampled per rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| inNib | input | 4 | Slice of the recovered stream; bit 0 is the earliest bit |
| outWord | output | 10 | Assembled symbol; bit 0 is the earliest bit |
| outValid | output | 1 | High for one cycle when `outWord` carries a new symbol |

## Verification
A slice sampled at edge e is held in the staging register after that edge. The controller decides at the same edge whether ten bits are now present. The output bank then captures the symbol at edge e+1, so a symbol whose last slice is sampled at edge e is checked just after edge e+1. The bench drives each slice at a falling edge and samples the outputs 1 ns after every rising edge. For each edge index it works out from the slice arithmetic whether a strobe is due and which serial bits the symbol must hold. In the cycles with no strobe, it compares `outWord` against the last expected symbol.

// File: rtl/nib2sym_pkg.sv
package nib2sym_pkg;

  // Configuration: input slice width and output symbol width.
  localparam int NIB_W = 4;
  localparam int SYM_W = 10;

  function automatic int gcdOf(input int a, input int b);
    int x;
    int y;
    int t;
    x = a;
    y = b;
    while (y != 0) begin
      t = x % y;
      x = y;
      y = t;
    end
    return x;
  endfunction

  // The fill level only ever takes multiples of the gcd. The most bits waiting
  // before a new slice arrives is SYM_W - gcd, so the staging depth is that plus a slice.
  localparam int STEP_W     = gcdOf(NIB_W, SYM_W);
  localparam int STAGE_W    = SYM_W - STEP_W + NIB_W;
  localparam int SHIFT_SPAN = STAGE_W - SYM_W;
  localparam int FILL_W     = $clog2(STAGE_W + 1);
  localparam int OFS_W      = (SHIFT_SPAN < 1) ? 1 : $clog2(SHIFT_SPAN + 1);

  // Strobes from control to datapath.
  typedef struct packed {
    logic             capture;
    logic [OFS_W-1:0] offset;
  } gbStrobe_t;

endpackage

// File: rtl/nib2sym_ctrl.sv
module nib2sym_ctrl
  import nib2sym_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  output gbStrobe_t strb
);

  logic [FILL_W-1:0] fillQ;
  logic [FILL_W-1:0] fillSum;
  logic              capNext;
  logic [OFS_W-1:0]  offNext;
  gbStrobe_t         strbQ;

  always_comb begin
    fillSum = fillQ + FILL_W'(NIB_W);
    capNext = (fillSum >= FILL_W'(SYM_W));
    // The oldest pending bit sits at STAGE_W - fillSum once the new slice has shifted in.
    offNext = OFS_W'(FILL_W'(STAGE_W) - fillSum);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fillQ <= '0;
      strbQ <= '0;
    end else begin
      fillQ         <= capNext ? (fillSum - FILL_W'(SYM_W)) : fillSum;
      strbQ.capture <= capNext;
      strbQ.offset  <= capNext ? offNext : '0;
    end
  end

  assign strb = strbQ;

endmodule

// File: rtl/nib2sym_dpath.sv
module nib2sym_dpath
  import nib2sym_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [NIB_W-1:0] inNib,
  input  gbStrobe_t        strb,
  output logic [SYM_W-1:0] outWord,
  output logic             outValid
);

  logic [STAGE_W-1:0] stageQ;
  logic [SYM_W-1:0]   pickBits;
  logic [SYM_W-1:0]   wordQ;
  logic               validQ;

  // Staging register: the newest slice enters at the top, the oldest bits sit at the bottom.
  always_ff @(posedge clk) begin
    if (!rstN) stageQ <= '0;
    else       stageQ <= {inNib, stageQ[STAGE_W-1:NIB_W]};
  end

  // One multiplexer per output bit, steered by the alignment offset.
  for (genvar j = 0; j < SYM_W; j++) begin : g_pick
    always_comb begin
      pickBits[j] = 1'b0;
      for (int o = 0; o <= SHIFT_SPAN; o++) begin
        if (strb.offset == OFS_W'(o)) pickBits[j] = stageQ[j + o];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wordQ  <= '0;
      validQ <= 1'b0;
    end else begin
      validQ <= strb.capture;
      if (strb.capture) wordQ <= pickBits;
    end
  end

  assign outWord  = wordQ;
  assign outValid = validQ;

endmodule

// File: rtl/nib2sym_gearbox.sv
module nib2sym_gearbox
  import nib2sym_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [NIB_W-1:0] inNib,
  output logic [SYM_W-1:0] outWord,
  output logic             outValid
);

  gbStrobe_t strb;

  nib2sym_ctrl ctrl_i (
    .clk  (clk),
    .rstN (rstN),
    .strb (strb)
  );

  nib2sym_dpath dpath_i (
    .clk      (clk),
    .rstN     (rstN),
    .inNib    (inNib),
    .strb     (strb),
    .outWord  (outWord),
    .outValid (outValid)
  );

endmodule

// File: rtl/nib2sym_gearbox_chk.sv
module nib2sym_gearbox_chk
  import nib2sym_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic [SYM_W-1:0] outWord,
  input logic             outValid
);

  logic [3:0] gapCnt;
  logic       seenValid;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      gapCnt    <= '0;
      seenValid <= 1'b0;
    end else if (outValid) begin
      gapCnt    <= 4'd1;
      seenValid <= 1'b1;
    end else if (gapCnt != 4'hF) begin
      gapCnt <= gapCnt + 4'd1;
    end
  end

  AST_RESET_CLEAR: assert property (@(posedge clk) !rstN |=> (!outValid && outWord == '0)); // R1

  AST_NO_ADJACENT_VALID: assert property (@(posedge clk) disable iff (!rstN) outValid |=> !outValid); // R2

  AST_VALID_SPACING: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && seenValid) |-> (gapCnt == 4'd2 || gapCnt == 4'd3)); // R2

  AST_HOLD_WORD: assert property (@(posedge clk) disable iff (!rstN) !outValid |-> $stable(outWord)); // R5

endmodule

bind nib2sym_gearbox nib2sym_gearbox_chk chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .outWord  (outWord),
  .outValid (outValid)
);

// File: tb/nib2sym_gearbox_tb_top.sv
`timescale 1ns/1ps
module nib2sym_gearbox_tb_top;
  import nib2sym_pkg::*;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic [NIB_W-1:0] inNib = '0;
  logic [SYM_W-1:0] outWord;
  logic             outValid;

  int nCompared = 0;
  int nMismatch = 0;
  logic [SYM_W-1:0] lastWord;
  bit restarted = 1'b0;

  always #4 clk = ~clk;

  nib2sym_gearbox dut_i (
    .clk      (clk),
    .rstN     (rstN),
    .inNib    (inNib),
    .outWord  (outWord),
    .outValid (outValid)
  );

  function automatic logic [3:0] nibVal(input int pat, input int i);
    logic [31:0] v;
    case (pat)
      0:       v = 32'(i);
      1:       v = (i % 2 == 0) ? 32'h5 : 32'hA;
      2:       v = 32'(i * 7 + 3) ^ 32'(i >> 3);
      3:       v = 32'(1) << (i % 4 + (i / 4) % 2);
      default: v = (i % 9 == 8) ? 32'h0 : 32'hF;
    endcase
    return v[3:0];
  endfunction

  function automatic logic serialBit(input int pat, input int s);
    logic [3:0] n;
    n = nibVal(pat, s / 4);
    return n[s % 4];
  endfunction

  task automatic check(input string req, input logic [SYM_W-1:0] act, input logic [SYM_W-1:0] exp);
    nCompared++;
    if (act !== exp) begin
      nMismatch++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic runStream(input int pat, input int len);
    @(negedge clk);
    rstN  = 1'b0;
    inNib = 4'hF;
    repeat (2) @(posedge clk);
    #1;
    check("R1 valid in reset", SYM_W'(outValid), '0);
    check("R1 word in reset", outWord, '0);
    lastWord = '0;
    @(negedge clk);
    rstN = 1'b1;
    for (int e = 0; e < len; e++) begin
      logic expValid;
      if (e > 0) @(negedge clk);
      inNib = nibVal(pat, e);
      @(posedge clk);
      #1;
      expValid = (e % 5 == 3) || (e % 5 == 0 && e > 0);
      check("R2 valid timing", SYM_W'(outValid), SYM_W'(expValid));
      if (expValid) begin
        int k;
        logic [SYM_W-1:0] expWord;
        k = (e % 5 == 3) ? 2 * (e / 5) : 2 * (e / 5) - 1;
        for (int j = 0; j < SYM_W; j++) expWord[j] = serialBit(pat, 10 * k + j);
        if (restarted && k == 0)  check("R6 first word after restart", outWord, expWord);
        else if (k % 2 == 0)      check("R3 even word order", outWord, expWord);
        else                      check("R4 odd word alignment", outWord, expWord);
        lastWord = expWord;
      end else begin
        check("R5 hold", outWord, lastWord);
      end
    end
    restarted = 1'b1;
  endtask

  initial begin
    #(8 * 200000);
    nMismatch++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCompared, nMismatch);
    $finish;
  end

  initial begin
    runStream(0, 60);
    runStream(1, 37);   // stops mid-group, reset drops partial bits (R6)
    runStream(2, 203);
    runStream(3, 8);    // two bits still pending when reset hits (R6)
    runStream(4, 100);
    runStream(2, 25);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCompared, nMismatch);
    $finish;
  end

endmodule